// File: doc/BRIEF.md
# MDIO Management Master

This block runs one read or one write at a time on a two-wire PHY management bus. It makes the management clock from the system clock: each half-period lasts a programmable number of system clocks. It drives the data line through a separate output-enable, so a pad or an external tri-state buffer can hand the line to the PHY during a read.

The host side starts a transaction with a one-cycle `start_i`. At that moment it also supplies the direction, a 5-bit PHY address, a 5-bit register address and, for a write, a 16-bit data word. When the frame ends, the block pulses `done_o` for one cycle. At the same edge it updates the read data and the error flag. An error means that no PHY answered during turnaround; the read data is then forced to zero.

Every frame has 64 bit slots, counted from 0:
- slots 0 to 31 are the preamble;
- slots 32 to 45 carry the header;
- on a write, slots 46 to 63 carry the turnaround and the data;
- on a read, slot 46 is turnaround, slot 47 is the presence check, and slots 48 to 63 carry the data.

Top module: `mdio_master`

## Requirements
- R1: After reset, and whenever no transaction runs, `mdc_o` is 0, `mdio_o` is 1, `mdio_oe_o` is 1 and `done_o` is 0. After reset, `rdata_o` and `err_o` are 0.
- R2: A transaction begins with 32 bit slots (slots 0 to 31). In each of these slots `mdio_o` is 1 and `mdio_oe_o` is 1.
- R3: Slots 32 to 45 carry the header, most significant bit first: start code 01, then the opcode (10 for read, 01 for write), then `phy_addr_i`, then `reg_addr_i`. All four fields are captured when the command is accepted.
- R4: Every bit slot is made of a low phase followed by a high phase of `mdc_o`. Each phase lasts H system clocks, where H is `half_div_i` captured at acceptance, and a value of 0 acts as 1. `mdio_o` and `mdio_oe_o` change only at the edge that lowers `mdc_o` or later in the low phase, never while `mdc_o` is high.
- R5: On a read, `mdio_oe_o` drops to 0 at the start of slot 46, with `mdc_o` low. It stays 0 through slot 63.
- R6: On a read, `mdio_i` is sampled at the last system clock of the low phase of slot 47. If it is 1, the completion reports `err_o`=1 and `rdata_o`=0.
- R7: On a read, `mdio_i` is sampled at the last system clock of the low phase of each of slots 48 to 63. The 16 samples form `rdata_o`, first sample in bit 15. When the slot-47 sample was 0, `err_o` is 0.
- R8: On a write, slots 46 and 47 carry the turnaround pattern 10 and slots 48 to 63 carry `wdata_i`, most significant bit first. The completion reports `err_o`=0 and `rdata_o`=0.
- R9: The edge that ends the high phase of slot 63 lowers `mdc_o`, returns `mdio_oe_o` to 1 and `mdio_o` to 1, and raises `done_o` for exactly one cycle. `rdata_o` and `err_o` keep their values until the next completion.
- R10: `start_i` is accepted only when no transaction is running. A `start_i` during a transaction has no effect on that transaction's waveform or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a transaction (taken only when idle) |
| read_i | input | 1 | 1 = read, 0 = write |
| phy_addr_i | input | 5 | PHY address |
| reg_addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| half_div_i | input | DIV_W | System clocks per management-clock half-period (0 acts as 1) |
| mdio_i | input | 1 | Data line as seen at the pad |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line drive value |
| mdio_oe_o | output | 1 | Data line output-enable |
| rdata_o | output | 16 | Read data of the last completed transaction |
| err_o | output | 1 | Last read found no PHY |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A command accepted at edge 0 gives `mdc_o` low for system clocks 1 to H after that edge, high for H+1 to 2H, and so on. Slot s therefore occupies clocks 2Hs+1 to 2Hs+2H. `done_o` is due in the single cycle after clock 128H, together with the final `rdata_o` and `err_o`. The bench model walks slots, phases and half-period counts in that order and compares every output half a clock after each rising edge. It also presents each PHY bit at the first cycle of its slot, so the bit is steady when the design samples it at the end of the low phase.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_LEN   = 32;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 16;
  localparam int SLOTS     = PRE_LEN + 2 + 2 + 2 * ADDR_W + 2 + DATA_W;
  localparam int SLOT_W    = $clog2(SLOTS);

  localparam logic [SLOT_W-1:0] SLOT_HDR_END = SLOT_W'(PRE_LEN + 4 + 2 * ADDR_W - 1);
  localparam logic [SLOT_W-1:0] SLOT_SENSE   = SLOT_W'(PRE_LEN + 4 + 2 * ADDR_W + 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST    = SLOT_W'(SLOTS - 1);

  localparam logic [1:0] SOF_CODE = 2'b01;
  localparam logic [1:0] OP_RD    = 2'b10;
  localparam logic [1:0] OP_WR    = 2'b01;
  localparam logic [1:0] TA_WR    = 2'b10;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] lim_q, cnt_q;
  logic             phase_q;
  logic             last;

  assign last   = run_i && (cnt_q == lim_q);
  assign rise_o = last && !phase_q;
  assign fall_o = last && phase_q;
  assign mdc_o  = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_q   <= '0;
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (load_i) begin
      // zero divider behaves as one clock per half-period
      lim_q   <= (half_div_i == '0) ? '0 : half_div_i - 1'b1;
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (run_i) begin
      if (last) begin
        cnt_q   <= '0;
        phase_q <= ~phase_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              read_i,
  input  logic [ADDR_W-1:0] phy_addr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              busy_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o
);
  localparam int TAIL_W = 2 + DATA_W;

  logic [SLOTS-1:0]  frame_q;
  logic [SLOT_W-1:0] slot_q;
  logic              busy_q, rd_q, oe_q, err_q;
  logic [DATA_W-1:0] rx_q;
  logic [TAIL_W-1:0] tail;
  logic              finish;

  assign tail      = read_i ? {TAIL_W{1'b1}} : {TA_WR, wdata_i};
  assign finish    = fall_i && (slot_q == SLOT_LAST);
  assign busy_o    = busy_q;
  assign mdio_o    = busy_q ? frame_q[SLOTS-1] : 1'b1;
  assign mdio_oe_o = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '1;
      slot_q  <= '0;
      busy_q  <= 1'b0;
      rd_q    <= 1'b0;
      oe_q    <= 1'b1;
      err_q   <= 1'b0;
      rx_q    <= '0;
      done_o  <= 1'b0;
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (load_i) begin
        frame_q <= {{PRE_LEN{1'b1}}, SOF_CODE, read_i ? OP_RD : OP_WR,
                    phy_addr_i, reg_addr_i, tail};
        slot_q  <= '0;
        busy_q  <= 1'b1;
        rd_q    <= read_i;
        err_q   <= 1'b0;
        rx_q    <= '0;
      end else if (busy_q) begin
        if (rise_i && rd_q) begin
          if (slot_q == SLOT_SENSE) err_q <= mdio_i;
          if (slot_q > SLOT_SENSE)  rx_q  <= {rx_q[DATA_W-2:0], mdio_i};
        end
        if (fall_i) begin
          frame_q <= {frame_q[SLOTS-2:0], 1'b1};
          slot_q  <= slot_q + 1'b1;
          // release the line as MDC falls into the turnaround slot
          if (rd_q && slot_q == SLOT_HDR_END) oe_q <= 1'b0;
        end
        if (finish) begin
          busy_q  <= 1'b0;
          oe_q    <= 1'b1;
          done_o  <= 1'b1;
          err_o   <= rd_q && err_q;
          rdata_o <= (rd_q && !err_q) ? rx_q : '0;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              read_i,
  input  logic [ADDR_W-1:0] phy_addr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DIV_W-1:0]  half_div_i,
  input  logic              mdio_i,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic              done_o
);
  logic busy, accept, rise, fall;

  assign accept = start_i && !busy;

  mdio_clk_gen #(.DIV_W(DIV_W)) u_clk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .run_i      (busy),
    .half_div_i (half_div_i),
    .mdc_o      (mdc_o),
    .rise_o     (rise),
    .fall_o     (fall)
  );

  mdio_frame u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .read_i     (read_i),
    .phy_addr_i (phy_addr_i),
    .reg_addr_i (reg_addr_i),
    .wdata_i    (wdata_i),
    .rise_i     (rise),
    .fall_i     (fall),
    .mdio_i     (mdio_i),
    .busy_o     (busy),
    .mdio_o     (mdio_o),
    .mdio_oe_o  (mdio_oe_o),
    .done_o     (done_o),
    .rdata_o    (rdata_o),
    .err_o      (err_o)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
  import mdio_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_i,
  input logic              mdc_o,
  input logic              mdio_o,
  input logic              mdio_oe_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              err_o,
  input logic              done_o
);
  a_r1_idle_lines: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (!mdc_o && mdio_o && mdio_oe_o));

  a_r4_data_steady_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdc_o |-> ($stable(mdio_o) && $stable(mdio_oe_o)));

  a_r5_turn_with_mdc_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mdio_oe_o) |-> !mdc_o);

  a_r6_err_zero_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rdata_o == '0));

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_done_handback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_i && mdio_oe_o && !mdc_o));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_i    (busy),
  .mdc_o     (mdc_o),
  .mdio_o    (mdio_o),
  .mdio_oe_o (mdio_oe_o),
  .rdata_o   (rdata_o),
  .err_o     (err_o),
  .done_o    (done_o)
);

// File: tb/mdio_master_test.sv
module mdio_master_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        read_i = 1'b0;
  logic [4:0]  phy_addr_i = '0;
  logic [4:0]  reg_addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [7:0]  half_div_i = 8'd1;
  logic        mdio_i = 1'b1;
  logic        mdc_o, mdio_o, mdio_oe_o, err_o, done_o;
  logic [15:0] rdata_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk_i = ~clk_i;

  mdio_master uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .read_i(read_i),
    .phy_addr_i(phy_addr_i), .reg_addr_i(reg_addr_i), .wdata_i(wdata_i),
    .half_div_i(half_div_i), .mdio_i(mdio_i), .mdc_o(mdc_o), .mdio_o(mdio_o),
    .mdio_oe_o(mdio_oe_o), .rdata_o(rdata_o), .err_o(err_o), .done_o(done_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic idle_check(input string req, input logic [15:0] rd_exp, input logic er_exp);
    chk(req, "mdc", int'(mdc_o), 0);
    chk(req, "mdio", int'(mdio_o), 1);
    chk(req, "oe", int'(mdio_oe_o), 1);
    chk(req, "done", int'(done_o), 0);
    chk(req, "rdata", int'(rdata_o), int'(rd_exp));
    chk(req, "err", int'(err_o), int'(er_exp));
  endtask

  // reference model: walks slots, phases and half-period counts
  task automatic txn(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                     input logic [15:0] wd, input logic [7:0] hd,
                     input bit phy_absent, input logic [15:0] phy_data, input bit poke);
    logic [13:0] hdr;
    logic [17:0] tl;
    logic [15:0] rd_exp;
    logic        er_exp;
    int          h;
    bit          ebit;
    bit          eoe;
    hdr = {2'b01, rd ? 2'b10 : 2'b01, phy, rg};
    tl  = {2'b10, wd};
    h   = (hd == 0) ? 1 : int'(hd);
    @(negedge clk_i);
    start_i = 1'b1; read_i = rd; phy_addr_i = phy; reg_addr_i = rg;
    wdata_i = wd; half_div_i = hd;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int s = 0; s < 64; s++) begin
      for (int p = 0; p < 2; p++) begin
        for (int k = 0; k < h; k++) begin
          if (p == 0 && k == 0) begin
            if (rd && s == 47) mdio_i = phy_absent;
            else if (rd && s >= 48) mdio_i = phy_data[63-s];
            else mdio_i = 1'b1;
            if (poke && s == 10) begin
              // R10: command during a transaction, with different fields
              start_i = 1'b1; read_i = ~rd; phy_addr_i = ~phy; half_div_i = 8'd1;
            end
            if (poke && s == 12) start_i = 1'b0;
          end
          eoe = !(rd && s >= 46);
          if (s < 32) ebit = 1'b1;
          else if (s < 46) ebit = hdr[45-s];
          else ebit = rd ? 1'b1 : tl[63-s];
          chk("R4", "mdc phase", int'(mdc_o), p);
          chk(rd ? "R5" : "R8", "oe", int'(mdio_oe_o), int'(eoe));
          if (eoe)
            chk(s < 32 ? "R2" : (s < 46 ? "R3" : "R8"), "mdio bit", int'(mdio_o), int'(ebit));
          chk("R9", "done early", int'(done_o), 0);
          @(negedge clk_i);
        end
      end
    end
    rd_exp = (rd && !phy_absent) ? phy_data : 16'h0;
    er_exp = rd && phy_absent;
    chk("R9", "done", int'(done_o), 1);
    chk("R9", "mdc end", int'(mdc_o), 0);
    chk("R9", "oe end", int'(mdio_oe_o), 1);
    chk("R9", "mdio end", int'(mdio_o), 1);
    chk(rd ? (phy_absent ? "R6" : "R7") : "R8", "rdata", int'(rdata_o), int'(rd_exp));
    chk(rd ? "R6" : "R8", "err", int'(err_o), int'(er_exp));
    @(negedge clk_i);
    idle_check("R9", rd_exp, er_exp);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    idle_check("R1", 16'h0, 1'b0);
    rst_ni = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      idle_check("R1", 16'h0, 1'b0);
    end
    txn(1'b0, 5'h15, 5'h0A, 16'hA5C3, 8'd1, 1'b0, 16'h0, 1'b0);
    txn(1'b1, 5'h01, 5'h1F, 16'h0000, 8'd3, 1'b0, 16'hB29D, 1'b0);
    txn(1'b1, 5'h1E, 5'h02, 16'h0000, 8'd2, 1'b1, 16'hFFFF, 1'b0);
    txn(1'b0, 5'h00, 5'h11, 16'h7E01, 8'd0, 1'b0, 16'h0, 1'b0);
    txn(1'b1, 5'h0C, 5'h05, 16'h0000, 8'd2, 1'b0, 16'h8001, 1'b1);
    txn(1'b0, 5'h13, 5'h1C, 16'h1234, 8'd2, 1'b0, 16'h0, 1'b1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      idle_check("R1", 16'h0, 1'b0);
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule